// File: doc/BRIEF.md
# Cascadable Serial Display-Data Shift Register

This block takes display data from a three-wire serial bus made of a data line, a bit clock and an enable line. All three lines are brought into the system-clock domain through two-flop synchronizers. A rising edge of the bit clock moves one data bit into a shift register, but only while the enable line is high. The shift register is built from equal sections. A mode input chooses how many of these sections are chained, so the shift length can be one, two or three section widths. With the default parameters that gives 32, 64 or 96 bits.

A parallel display latch drives the segment outputs. It keeps the previous frame while a new frame is shifted in. When the enable line drops, the active part of the shift register is copied into the latch in one system-clock cycle, and the bits of unused sections are written as zero. The last active stage feeds a serial output register that updates on the falling edge of the bit clock, so a second device wired behind this one sees a settled bit at its own rising edge. An output-enable signal follows the enable line, so the serial output can be tri-stated at the pad.

Top module: `serdisp_chain`

## Requirements
- R1: The mode value picks the shift length: 0 gives one section (32 bits), 1 gives two sections (64 bits), and 2 or 3 gives all three sections (96 bits). After a full frame of L bits, the first bit shifted in sits at latch index L-1 and the last bit shifted in sits at index 0.
- R2: A synchronized rising edge of ser_clk shifts in the synchronized ser_data only while ser_en is high. Bit-clock pulses while ser_en is low leave the shift register unchanged, which the next frame's latched result shows.
- R3: On a high-to-low transition of ser_en, the active bits are copied to disp_latch, and every bit above the active length is written as 0.
- R4: disp_latch changes only on that load. While a frame is being shifted in, it holds the previous frame.
- R5: ser_out carries the last active stage (index L-1). It updates only on a synchronized falling edge of ser_clk, so it keeps its old value between a rising edge and the falling edge that follows.
- R6: ser_out_oe equals ser_en delayed by the two synchronizer stages. It is 1 only while the enable line is high.
- R7: A change on mode is taken only while the synchronized enable is low. A change made during a frame does not alter that frame's length or its latched result.
- R8: Reset clears the shift register, disp_latch, ser_out and ser_out_oe to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, at most a quarter of clk |
| ser_data | input | 1 | Serial data, changed on the falling bit-clock edge |
| ser_en | input | 1 | Transfer enable; high shifts, the falling edge loads the latch |
| mode | input | MODE_W (2) | Section count select: 0 gives 32 bits, 1 gives 64, 2 or 3 gives 96 |
| ser_out | output | 1 | Cascade output from the last active stage |
| ser_out_oe | output | 1 | Output enable for the cascade pad |
| disp_latch | output | TOT_W (96) | Parallel display data |

## Verification
The bound checker watches several rules on every cycle. The shift register stays frozen while the synchronized enable is low. The latch moves only in the cycle after an enable fall, and a one-section load leaves the upper sections at zero. The cascade output changes only after a falling bit-clock edge. The output enable tracks ser_en two cycles late. The mode register holds while a transfer is open. Only the bench's frames can show the rest: the ordering of bits into the latch, the tap moving with the mode, old content surviving ignored clock pulses, and a mid-frame mode change being deferred. For these, the bench compares the latch and the serial output against a reference model of the shift path.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
   localparam int SDC_SEC_W_DEF   = 32;
   localparam int SDC_NUM_SEC_DEF = 3;
   localparam int SDC_SYNC_DEF    = 2;

   // number of mode bits needed to name every section count
   function automatic int sdc_mode_bits(input int n_sec);
      return (n_sec < 2) ? 1 : $clog2(n_sec);
   endfunction
endpackage

// File: rtl/sdc_sync.sv
module sdc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sdc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] ff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= '0;
      else        ff <= {ff[STAGES-2:0], d};
   end

   assign q = ff[STAGES-1];
endmodule

// File: rtl/sdc_shift_chain.sv
module sdc_shift_chain #(
   parameter int SEC_W   = 32,
   parameter int NUM_SEC = 3,
   localparam int TOT_W  = SEC_W * NUM_SEC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift,
   input  logic             din,
   output logic [TOT_W-1:0] sr
);
   if (SEC_W < 2) begin : g_bad_width
      $error("sdc_shift_chain: SEC_W must be at least 2");
   end

   for (genvar i = 0; i < NUM_SEC; i++) begin : g_sec
      logic [SEC_W-1:0] sec_q;
      logic             sin;

      if (i == 0) begin : g_head
         assign sin = din;
      end else begin : g_link
         assign sin = sr[i*SEC_W-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     sec_q <= '0;
         else if (shift) sec_q <= {sec_q[SEC_W-2:0], sin};
      end

      assign sr[i*SEC_W +: SEC_W] = sec_q;
   end
endmodule

// File: rtl/sdc_out_stage.sv
module sdc_out_stage #(
   parameter int SEC_W   = 32,
   parameter int NUM_SEC = 3,
   parameter int MODE_W  = 2,
   localparam int TOT_W  = SEC_W * NUM_SEC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TOT_W-1:0]  sr,
   input  logic [MODE_W-1:0] mode_eff,
   input  logic              load,
   input  logic              tap_upd,
   output logic [TOT_W-1:0]  disp_q,
   output logic              so_q
);
   logic [TOT_W-1:0] masked;
   logic             tap;

   for (genvar i = 0; i < NUM_SEC; i++) begin : g_mask
      logic act;
      assign act = (int'(mode_eff) >= i);
      assign masked[i*SEC_W +: SEC_W] = act ? sr[i*SEC_W +: SEC_W] : '0;
   end

   always_comb begin
      tap = 1'b0;
      for (int i = 0; i < NUM_SEC; i++) begin
         if (int'(mode_eff) == i) tap = sr[(i+1)*SEC_W-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_q <= '0;
         so_q   <= 1'b0;
      end else begin
         if (load)    disp_q <= masked;
         if (tap_upd) so_q   <= tap;
      end
   end
endmodule

// File: rtl/serdisp_chain.sv
module serdisp_chain
   import sdc_pkg::*;
#(
   parameter int  SEC_W       = SDC_SEC_W_DEF,
   parameter int  NUM_SEC     = SDC_NUM_SEC_DEF,
   parameter int  SYNC_STAGES = SDC_SYNC_DEF,
   localparam int TOT_W       = SEC_W * NUM_SEC,
   localparam int MODE_W      = sdc_mode_bits(NUM_SEC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              ser_en,
   input  logic [MODE_W-1:0] mode,
   output logic              ser_out,
   output logic              ser_out_oe,
   output logic [TOT_W-1:0]  disp_latch
);
   if (NUM_SEC < 2) begin : g_bad_count
      $error("serdisp_chain: NUM_SEC must be at least 2");
   end

   logic sclk_lvl, sclk_prev, en_lvl, en_prev, din_lvl;
   logic sclk_rise, sclk_fall, en_fall, shift_en;
   logic [MODE_W-1:0] mode_q, mode_eff;
   logic [TOT_W-1:0]  sr;

   sdc_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (.clk(clk), .rst_n(rst_n), .d(ser_clk),  .q(sclk_lvl));
   sdc_sync #(.STAGES(SYNC_STAGES)) u_sync_en  (.clk(clk), .rst_n(rst_n), .d(ser_en),   .q(en_lvl));
   sdc_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (.clk(clk), .rst_n(rst_n), .d(ser_data), .q(din_lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         en_prev   <= 1'b0;
         mode_q    <= '0;
      end else begin
         sclk_prev <= sclk_lvl;
         en_prev   <= en_lvl;
         if (!en_lvl) mode_q <= mode;
      end
   end

   assign sclk_rise = sclk_lvl & ~sclk_prev;
   assign sclk_fall = ~sclk_lvl & sclk_prev;
   assign en_fall   = ~en_lvl & en_prev;
   assign shift_en  = sclk_rise & en_lvl;

   // out-of-range mode codes select the full chain
   assign mode_eff = (int'(mode_q) >= NUM_SEC) ? MODE_W'(NUM_SEC - 1) : mode_q;

   sdc_shift_chain #(.SEC_W(SEC_W), .NUM_SEC(NUM_SEC)) u_chain (
      .clk(clk), .rst_n(rst_n), .shift(shift_en), .din(din_lvl), .sr(sr)
   );

   sdc_out_stage #(.SEC_W(SEC_W), .NUM_SEC(NUM_SEC), .MODE_W(MODE_W)) u_out (
      .clk(clk), .rst_n(rst_n), .sr(sr), .mode_eff(mode_eff),
      .load(en_fall), .tap_upd(sclk_fall),
      .disp_q(disp_latch), .so_q(ser_out)
   );

   assign ser_out_oe = en_lvl;
endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
   parameter int SEC_W   = 32,
   parameter int NUM_SEC = 3,
   parameter int MODE_W  = 2,
   localparam int TOT_W  = SEC_W * NUM_SEC
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ser_en,
   input logic              ser_out,
   input logic              ser_out_oe,
   input logic [TOT_W-1:0]  disp_latch,
   input logic [TOT_W-1:0]  sr,
   input logic              en_lvl,
   input logic              en_fall,
   input logic              sclk_fall,
   input logic [MODE_W-1:0] mode_q
);
   // R2
   frozen_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en_lvl) |-> (sr == $past(sr)));

   // R3
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(en_fall) && ($past(mode_q) == '0)) |-> (disp_latch[TOT_W-1:SEC_W] == '0));

   // R4
   latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_latch != $past(disp_latch)) |-> $past(en_fall));

   // R5
   tap_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_out != $past(ser_out)) |-> $past(sclk_fall));

   // R6
   oe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_out_oe == $past(ser_en, 2));

   // R7
   mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_lvl) |-> $stable(mode_q));
endmodule

bind serdisp_chain sdc_checker #(.SEC_W(SEC_W), .NUM_SEC(NUM_SEC), .MODE_W(MODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_out(ser_out),
   .ser_out_oe(ser_out_oe), .disp_latch(disp_latch), .sr(sr),
   .en_lvl(en_lvl), .en_fall(en_fall), .sclk_fall(sclk_fall), .mode_q(mode_q)
);

// File: tb/serdisp_chain_test.sv
module serdisp_chain_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic        ser_out, ser_out_oe;
   logic [95:0] disp_latch;

   int   n_chk = 0, n_bad = 0;
   bit   done = 0;
   logic [95:0] model = '0;
   logic [95:0] exp_latch = '0;
   logic        exp_so = 1'b0;

   always #4 clk = ~clk;

   serdisp_chain uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_en(ser_en), .mode(mode), .ser_out(ser_out), .ser_out_oe(ser_out_oe),
      .disp_latch(disp_latch)
   );

   function automatic int len_of(input logic [1:0] m);
      return (m == 2'd0) ? 32 : (m == 2'd1) ? 64 : 96;
   endfunction

   function automatic logic [95:0] mask_of(input logic [1:0] m);
      return {96{1'b1}} >> (96 - len_of(m));
   endfunction

   task automatic chk(input string req, input logic [95:0] got, input logic [95:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic send_bit(input logic b, input int len, input bit active);
      logic old_so;
      ser_data = b;
      repeat (4) @(negedge clk);
      old_so = exp_so;
      ser_clk = 1'b1;
      if (active) model = {model[94:0], b};
      repeat (3) @(negedge clk);
      chk("R5 hold before fall", {95'd0, ser_out}, {95'd0, old_so});
      @(negedge clk);
      ser_clk = 1'b0;
      exp_so = model[len-1];
      repeat (4) @(negedge clk);
      chk("R5 tap after fall", {95'd0, ser_out}, {95'd0, exp_so});
   endtask

   task automatic run_frame(input logic [1:0] fm, input int nbits, input logic [95:0] pat,
                            input bit mid_change, input logic [1:0] mid_mode);
      mode = fm;
      repeat (4) @(negedge clk);
      ser_en = 1'b1;
      repeat (4) @(negedge clk);
      chk("R6 oe high", {95'd0, ser_out_oe}, 96'd1);
      for (int k = 0; k < nbits; k++) begin
         send_bit(pat[nbits-1-k], len_of(fm), 1'b1);
         if (k == nbits / 2) begin
            chk("R4 latch holds mid-frame", disp_latch, exp_latch);
            if (mid_change) mode = mid_mode;
         end
      end
      ser_en = 1'b0;
      repeat (6) @(negedge clk);
      exp_latch = model & mask_of(fm);
      chk(mid_change ? "R7 mode deferred" : "R1 R3 latched frame", disp_latch, exp_latch);
      chk("R6 oe low", {95'd0, ser_out_oe}, 96'd0);
      mode = fm;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R8 reset state
      chk("R8 latch", disp_latch, '0);
      chk("R8 ser_out", {95'd0, ser_out}, '0);
      chk("R8 oe", {95'd0, ser_out_oe}, '0);

      // R1 single section, bit order
      run_frame(2'd0, 32, {64'd0, 32'hA5C3_0F81}, 0, 2'd0);
      chk("R1 order 32", disp_latch, {64'd0, 32'hA5C3_0F81});
      // R1 two sections, full chain
      run_frame(2'd1, 64, {32'd0, 64'h8000_0000_0000_0001}, 0, 2'd0);
      chk("R1 order 64", disp_latch, {32'd0, 64'h8000_0000_0000_0001});
      run_frame(2'd2, 96, {32'hDEAD_BEEF, 32'h1234_5678, 32'h0F0F_F0F0}, 0, 2'd0);
      // R1 code 3 behaves as full chain
      run_frame(2'd3, 96, {$urandom, $urandom, $urandom}, 0, 2'd0);

      // R2 pulses while enable is low are ignored
      for (int k = 0; k < 6; k++) send_bit(k[0], 96, 1'b0);
      chk("R2 latch unchanged by idle pulses", disp_latch, exp_latch);
      run_frame(2'd2, 5, 96'h1F, 0, 2'd0);
      chk("R2 old content kept", disp_latch, model);

      // R3 shorter frame after full one: upper sections zero
      run_frame(2'd0, 32, {64'd0, $urandom}, 0, 2'd0);
      chk("R3 upper zero", disp_latch[95:32] == 64'd0 ? 96'd1 : 96'd0, 96'd1);

      // R7 mode change during frame is deferred
      run_frame(2'd0, 32, {64'd0, $urandom}, 1, 2'd2);
      run_frame(2'd2, 40, {56'd0, $urandom, 8'h5A}, 1, 2'd1);

      // random frames
      for (int f = 0; f < 20; f++) begin
         logic [1:0] m;
         m = 2'($urandom_range(0, 3));
         run_frame(m, $urandom_range(1, 100), {$urandom, $urandom, $urandom},
                   ($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3)));
      end
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule